// File: doc/BRIEF.md
# Three-Input Post-Adder Accumulator

This block is the adder stage that follows a multiplier array in a signal-processing slice. The multiplier leaves its product in redundant form, as two vectors whose sum is the product. Here those two vectors and a third operand meet in a single three-input adder. A row of 3:2 carry-save cells first reduces the three inputs to two. A carry-propagate adder then resolves the pair. That adder is split into carry-select sections, and each section computes its carries by lookahead. The resolved value is captured in an output register.

A two-bit mode input chooses the third operand. It can be an external addend (multiply-add), the block's own registered result (accumulate), the result arriving from a neighbouring slice (cascade), or zero. A subtract control turns the operation into vectors minus third operand. It does this by inverting the selected operand and injecting a carry-in of one. A load control clears the feedback term in accumulate mode, so a new running sum can start without a reset cycle. The registered result is also driven on a cascade output, which is meant to feed the cascade input of the next slice.

The modes are fixed selections made each cycle, not states. The only stored state is the result register, which has two transitions. A synchronous reset clears it. When clock enable is high it is loaded with the new sum. Otherwise it holds.

Top module: `tri_post_adder`

## Requirements
- R1: With `rst` high at a rising clock edge, `p` becomes zero after that edge, whatever `ce` and the data inputs are.
- R2: With `mode` = 2'b00 and `sub` = 0, an enabled edge loads `p` with ext(`vec_s`) + ext(`vec_c`) + `addend`.
- R3: When `sgn` = 1, ext() sign-extends each 43-bit vector from bit 42 to 48 bits. When `sgn` = 0 it zero-extends.
- R4: With `mode` = 2'b01 and `load` = 0, the third operand is the current `p`, so each enabled edge adds the vector sum to the running result.
- R5: With `mode` = 2'b01 and `load` = 1, the third operand is zero. In every other mode `load` has no effect.
- R6: With `mode` = 2'b10, the third operand is `cas_in`.
- R7: With `mode` = 2'b11, the third operand is zero.
- R8: With `sub` = 1, the loaded value is ext(`vec_s`) + ext(`vec_c`) minus the selected third operand.
- R9: With `ce` = 0 and `rst` = 0, `p` keeps its value across the edge.
- R10: `cas_out` equals `p` in every cycle.
- R11: All sums wrap modulo 2^48 with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the result register |
| ce | input | 1 | Clock enable of the result register |
| mode | input | 2 | Third operand: 00 addend, 01 feedback, 10 cascade, 11 zero |
| load | input | 1 | Zero the feedback term in mode 01 |
| sub | input | 1 | 1: subtract the third operand |
| sgn | input | 1 | 1: sign-extend the vectors, 0: zero-extend |
| vec_s | input | 43 | First redundant product vector |
| vec_c | input | 43 | Second redundant product vector |
| addend | input | 48 | External addend |
| cas_in | input | 48 | Result from the preceding slice |
| p | output | 48 | Registered result |
| cas_out | output | 48 | Copy of `p` for the next slice |

## Verification
The hardest case to reach is a carry that starts in the lowest carry-select section and ripples through every section to the top. It needs long runs of propagate bits in the carry-save outputs, and random data rarely produces those. The sweep therefore mixes random operands with all-ones addends and boundary vectors near the 2^48 wrap point. It also runs long accumulation chains, in which the fed-back result takes arbitrary bit patterns, and applies every combination of mode, subtract, sign and load to each data pattern.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int PA_PROD_W = 43;
    localparam int PA_ACC_W  = 48;
    localparam int PA_SEC_W  = 8;

    typedef enum logic [1:0] {
        OPM_ADDEND  = 2'b00,
        OPM_ACCUM   = 2'b01,
        OPM_CASCADE = 2'b10,
        OPM_ZERO    = 2'b11
    } opm_e;

endpackage

// File: rtl/pa_opsel.sv
module pa_opsel
    import pa_pkg::*;
#(
    parameter int W = PA_ACC_W
) (
    input  opm_e           mode_i,
    input  logic           load_i,
    input  logic           sub_i,
    input  logic [W-1:0]   addend_i,
    input  logic [W-1:0]   fb_i,
    input  logic [W-1:0]   cas_i,
    output logic [W-1:0]   w_o
);

    logic [W-1:0] pick;

    always_comb begin
        unique case (mode_i)
            OPM_ADDEND:  pick = addend_i;
            OPM_ACCUM:   pick = load_i ? '0 : fb_i;
            OPM_CASCADE: pick = cas_i;
            OPM_ZERO:    pick = '0;
        endcase
    end

    // subtraction: ones' complement here, the +1 enters as the adder carry-in
    always_comb begin
        w_o = sub_i ? ~pick : pick;
    end

endmodule

// File: rtl/pa_csa.sv
module pa_csa #(
    parameter int W = 48
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    assign c_o[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
            if (i < W - 1) begin : g_car
                assign c_o[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/pa_cla_sec.sv
module pa_cla_sec #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         cout_o
);

    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W:0]   car;

    assign gen = a_i & b_i;
    assign prp = a_i ^ b_i;

    // every carry is formed directly from generate/propagate terms and cin
    always_comb begin
        logic term;
        logic grp;
        logic run;
        car[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            term = cin_i;
            for (int j = 0; j <= i; j++) begin
                term = term & prp[j];
            end
            grp = 1'b0;
            for (int j = 0; j <= i; j++) begin
                run = gen[j];
                for (int k = j + 1; k <= i; k++) begin
                    run = run & prp[k];
                end
                grp = grp | run;
            end
            car[i+1] = grp | term;
        end
    end

    assign s_o    = prp ^ car[W-1:0];
    assign cout_o = car[W];

endmodule

// File: rtl/pa_cpa.sv
module pa_cpa #(
    parameter int W     = 48,
    parameter int SEC_W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W:0]   sum_o
);

    // W must be a multiple of SEC_W
    localparam int NSEC = W / SEC_W;

    logic [NSEC:0] cc;
    logic [W-1:0]  s;

    assign cc[0] = cin_i;

    genvar k;
    generate
        for (k = 0; k < NSEC; k++) begin : g_sec
            if (k == 0) begin : g_first
                pa_cla_sec #(.W(SEC_W)) u_sec (
                    .a_i    (a_i[SEC_W-1:0]),
                    .b_i    (b_i[SEC_W-1:0]),
                    .cin_i  (cc[0]),
                    .s_o    (s[SEC_W-1:0]),
                    .cout_o (cc[1])
                );
            end else begin : g_sel
                logic [SEC_W-1:0] s0;
                logic [SEC_W-1:0] s1;
                logic             c0;
                logic             c1;
                pa_cla_sec #(.W(SEC_W)) u_lo (
                    .a_i    (a_i[k*SEC_W +: SEC_W]),
                    .b_i    (b_i[k*SEC_W +: SEC_W]),
                    .cin_i  (1'b0),
                    .s_o    (s0),
                    .cout_o (c0)
                );
                pa_cla_sec #(.W(SEC_W)) u_hi (
                    .a_i    (a_i[k*SEC_W +: SEC_W]),
                    .b_i    (b_i[k*SEC_W +: SEC_W]),
                    .cin_i  (1'b1),
                    .s_o    (s1),
                    .cout_o (c1)
                );
                assign s[k*SEC_W +: SEC_W] = cc[k] ? s1 : s0;
                assign cc[k+1]             = cc[k] ? c1 : c0;
            end
        end
    endgenerate

    assign sum_o = {cc[NSEC], s};

endmodule

// File: rtl/tri_post_adder.sv
module tri_post_adder
    import pa_pkg::*;
#(
    parameter int PROD_W = PA_PROD_W,
    parameter int ACC_W  = PA_ACC_W,
    parameter int SEC_W  = PA_SEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [1:0]        mode,
    input  logic              load,
    input  logic              sub,
    input  logic              sgn,
    input  logic [PROD_W-1:0] vec_s,
    input  logic [PROD_W-1:0] vec_c,
    input  logic [ACC_W-1:0]  addend,
    input  logic [ACC_W-1:0]  cas_in,
    output logic [ACC_W-1:0]  p,
    output logic [ACC_W-1:0]  cas_out
);

    localparam int EXT_W = ACC_W - PROD_W;

    logic [ACC_W-1:0] ext_s;
    logic [ACC_W-1:0] ext_c;
    logic [ACC_W-1:0] w_op;
    logic [ACC_W-1:0] csa_s;
    logic [ACC_W-1:0] csa_c;
    logic [ACC_W:0]   cpa_o;
    logic [ACC_W-1:0] sum_n;
    logic [ACC_W-1:0] p_q;
    opm_e             opm;

    assign opm = opm_e'(mode);

    // signed/unsigned extension of each redundant vector
    always_comb begin
        ext_s = sgn ? {{EXT_W{vec_s[PROD_W-1]}}, vec_s} : {{EXT_W{1'b0}}, vec_s};
        ext_c = sgn ? {{EXT_W{vec_c[PROD_W-1]}}, vec_c} : {{EXT_W{1'b0}}, vec_c};
    end

    pa_opsel #(.W(ACC_W)) u_sel (
        .mode_i   (opm),
        .load_i   (load),
        .sub_i    (sub),
        .addend_i (addend),
        .fb_i     (p_q),
        .cas_i    (cas_in),
        .w_o      (w_op)
    );

    pa_csa #(.W(ACC_W)) u_csa (
        .x_i (ext_s),
        .y_i (ext_c),
        .z_i (w_op),
        .s_o (csa_s),
        .c_o (csa_c)
    );

    pa_cpa #(.W(ACC_W), .SEC_W(SEC_W)) u_cpa (
        .a_i   (csa_s),
        .b_i   (csa_c),
        .cin_i (sub),
        .sum_o (cpa_o)
    );

    assign sum_n = cpa_o[ACC_W-1:0];

    // result register: reset clears, enable loads, otherwise hold
    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else if (ce) begin
            p_q <= sum_n;
        end
    end

    assign p       = p_q;
    assign cas_out = p_q;

    AST_CSA_KEEPS_SUM: assert property (@(posedge clk) disable iff (rst)
        (ACC_W'(csa_s + csa_c) == ACC_W'(ext_s + ext_c + w_op))); // R2

    AST_CPA_RESOLVES: assert property (@(posedge clk) disable iff (rst)
        (cpa_o == ({1'b0, csa_s} + {1'b0, csa_c} + {{ACC_W{1'b0}}, sub}))); // R11

    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
        (!ce |=> $stable(p))); // R9

    AST_ACC_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
        ((ce && opm == OPM_ACCUM && !load && !sub) |=>
         (p == ACC_W'($past(p) + $past(ext_s) + $past(ext_c))))); // R4

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        ((ce && opm == OPM_ACCUM && load && !sub) |=>
         (p == ACC_W'($past(ext_s) + $past(ext_c))))); // R5

endmodule

// File: tb/tri_post_adder_test.sv
`timescale 1ns/1ps
module tri_post_adder_test;

    localparam int PW = 43;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst, ce, load, sub, sgn;
    logic [1:0]    mode;
    logic [PW-1:0] vs, vc;
    logic [AW-1:0] addend, cas_in, p, cas_out;

    int            n_vec = 0;
    int            n_bad = 0;
    logic [AW-1:0] exp_p = '0;
    logic [63:0]   rng   = 64'h9E37_79B9_7F4A_7C15;
    string         tag_ov = "";

    always #2.5 clk = ~clk;

    tri_post_adder uut (
        .clk(clk), .rst(rst), .ce(ce), .mode(mode), .load(load), .sub(sub),
        .sgn(sgn), .vec_s(vs), .vec_c(vc), .addend(addend), .cas_in(cas_in),
        .p(p), .cas_out(cas_out)
    );

    function automatic logic [AW-1:0] ext(input logic [PW-1:0] v, input logic s);
        return s ? {{(AW-PW){v[PW-1]}}, v} : {{(AW-PW){1'b0}}, v};
    endfunction

    function automatic logic [63:0] nxt(input logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic rand_data();
        rng = nxt(rng); vs = rng[PW-1:0];
        rng = nxt(rng); vc = rng[PW-1:0];
        rng = nxt(rng); addend = rng[AW-1:0];
        rng = nxt(rng); cas_in = rng[AW-1:0];
    endtask

    // one clock: model update at the edge, compare at the following falling edge
    task automatic step();
        logic [AW-1:0] w;
        string t;
        @(posedge clk);
        case (mode)
            2'd0:    w = addend;
            2'd1:    w = load ? '0 : exp_p;
            2'd2:    w = cas_in;
            default: w = '0;
        endcase
        if (tag_ov != "")  t = tag_ov;
        else if (rst)      t = "R1";
        else if (!ce)      t = "R9";
        else if (sub)      t = "R8";
        else begin
            case (mode)
                2'd0:    t = sgn ? "R3" : "R2";
                2'd1:    t = load ? "R5" : "R4";
                2'd2:    t = "R6";
                default: t = "R7";
            endcase
        end
        if (rst)     exp_p = '0;
        else if (ce) exp_p = ext(vs, sgn) + ext(vc, sgn) + (sub ? (~w + 48'd1) : w);
        @(negedge clk);
        n_vec++;
        if (p !== exp_p) begin
            n_bad++;
            $display("FAIL %s p=%h expected %h", t, p, exp_p);
        end
        n_vec++;
        if (cas_out !== exp_p) begin
            n_bad++;
            $display("FAIL R10 cas_out=%h expected %h", cas_out, exp_p);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: run hung, actual incomplete expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; ce = 1'b1; load = 1'b0; sub = 1'b0; sgn = 1'b0; mode = 2'd0;
        vs = '1; vc = '1; addend = '1; cas_in = '1;
        @(negedge clk);
        step();                                   // R1 reset state
        rst = 1'b0;

        // R11: wrap at the top of the range, carry runs through every section
        tag_ov = "R11";
        mode = 2'd0; sgn = 1'b0; vs = 43'd1; vc = '0; addend = '1;
        step();
        vs = '1; vc = '1; addend = '1;
        step();
        sgn = 1'b1; vs = 43'd1; vc = '0; addend = '1;
        step();
        tag_ov = "R3";                            // R3 sign bit only
        vs = {1'b1, 42'd0}; vc = '0; addend = '0;
        step();
        sgn = 1'b0;
        step();
        tag_ov = "";

        // exhaustive control sweep over random data
        for (int rep = 0; rep < 40; rep++) begin
            for (int cmb = 0; cmb < 64; cmb++) begin
                rand_data();
                mode = cmb[1:0];
                sub  = cmb[2];
                sgn  = cmb[3];
                load = cmb[4];
                ce   = !cmb[5] || rep[0];
                rst  = ((rep * 64 + cmb) % 97) == 96;
                if (cmb[5] && rep[1]) addend = '1;
                step();
            end
        end
        rst = 1'b0; ce = 1'b1;

        // long accumulation chains: load then run, add and subtract
        for (int chain = 0; chain < 8; chain++) begin
            mode = 2'd1; load = 1'b1; sub = chain[0]; sgn = chain[1];
            rand_data();
            step();
            load = 1'b0;
            for (int i = 0; i < 30; i++) begin
                rand_data();
                step();
            end
        end

        // cascade fed from own output, chained through cas_in
        mode = 2'd2; sub = 1'b0; load = 1'b0;
        for (int i = 0; i < 20; i++) begin
            rand_data();
            cas_in = cas_out;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule